// File: doc/BRIEF.md
# SD Command Issue Engine

This block issues a single SD-card command on the CMD line and captures the card's reply. Software loads a 32-bit argument, then writes a 16-bit command word. That word holds the command index, the response shape, an optional busy wait, two direction bits and a start flag. The engine builds the 48-bit frame with its CRC7 and shifts it out on the falling edges of the card clock it generates. It then waits for no response, a 48-bit response or a 136-bit response, and stores the reply in four readable response words.

When the command finishes, the start flag in the command word drops back to 0. Software polls that flag to learn that the engine is idle. Three faults are reported: a missing response start bit within the programmed number of card-clock cycles, a CRC mismatch on a short reply, and an unsupported mode combination. Each fault sets a fail flag in the command word. The two reply faults also set a cause bit in a write-one-to-clear status word. When the command asks for a busy wait, a busy-done status bit is raised once the card lets DAT0 go high again.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, the command word (byte offset 0x00) and the status word (0x20) read 0, the timeout word (0x08) reads 0x00F00000, and the CMD output enable is low.
- R2: A started command is sent MSB first as 48 bits: start 0, transmit 1, 6-bit index (command word bits 5:0), the argument from offset 0x04, CRC7 (polynomial x^7+x^3+1) over the first 40 bits, and end bit 1. Each bit changes on a falling edge of sd_clk. For index 0 with argument 0 the final byte is 0x95, and for index 8 with argument 0x1AA it is 0x87.
- R3: Writing the command word with bit 15 set starts a command. Bit 15 reads 1 while the command runs and returns to 0 by hardware on completion. The other written fields stay readable.
- R4: With response bits 10:9 = 00, a 48-bit reply is received, and its bits 39:8 are stored in the word at 0x10.
- R5: If a short reply's CRC7, computed over its bits 47:8, does not match its bits 7:1, status bit 4 (0x10) is set and command-word bit 14 (fail) is set.
- R6: If no start bit (0) is seen on CMD within (timeout word + 1) sd_clk rising edges after the frame ends, status bit 6 (0x40) and the fail bit are set.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: With bit 9 (long) set, a 136-bit reply is received. Its last 128 bits are stored with bits 31:0 at 0x10, 63:32 at 0x14, 95:64 at 0x18 and 127:96 at 0x1C. No CRC check is applied.
- R9: With bit 11 (busy wait) set, the command stays active after the reply until DAT0 is sampled high. Status bit 10 (0x400) is then set.
- R10: A write to the command word while bit 15 reads 1 is ignored. No second frame is sent and the register keeps its value.
- R11: A start request with both bit 9 and bit 11 set is refused. No frame is sent, bit 15 stays 0 and the fail bit is set.
- R12: With bit 10 (no response) set, the CMD line is released after the end bit and the command completes without waiting for a reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, registered, valid one cycle after reg_addr |
| sd_clk | output | 1 | Generated card clock |
| sd_cmd_out | output | 1 | CMD line drive value |
| sd_cmd_oe | output | 1 | CMD line output enable |
| sd_cmd_in | input | 1 | CMD line sampled value |
| sd_dat0_in | input | 1 | DAT0 line, used for busy detection |

## Verification
The hardest situation to reach is a command write that arrives while an earlier command is still shifting out. From the ports that write looks like any other write, so it has to land inside the 48-bit frame window. The bench issues it a few cycles after a start request and checks that the card-side monitor sees exactly one frame. The busy phase is also hard to see, because the start flag must still read 1 after the reply has ended. A card model holds DAT0 low for a fixed number of card-clock cycles, and the bench reads the command word inside that window.

// File: rtl/sdce_pkg.sv
package sdce_pkg;
  localparam int TX_BITS    = 48;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;

  localparam int CW_GO    = 15;
  localparam int CW_FAIL  = 14;
  localparam int CW_BUSY  = 11;
  localparam int CW_NORSP = 10;
  localparam int CW_LONG  = 9;
  localparam logic [15:0] CW_MASK = 16'hCEFF;

  localparam int ST_CRC7  = 4;
  localparam int ST_CMDTO = 6;
  localparam int ST_BUSY  = 10;
  localparam logic [31:0] ST_MASK = 32'h0000_0450;

  localparam logic [31:0] TMO_RESET = 32'h00F0_0000;

  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_WAIT, S_RECV, S_CHECK, S_BUSY
  } sdce_state_e;
endpackage

// File: rtl/sdce_crc7.sv
module sdce_crc7 #(
  parameter int N = 40
) (
  input  logic [N-1:0] data,
  output logic [6:0]   crc
);
  always_comb begin
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = N - 1; i >= 0; i--) begin
      fb = data[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    crc = c;
  end
endmodule

// File: rtl/sdce_clkgen.sv
module sdce_clkgen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  output logic sd_clk,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int CW = $clog2(HALF + 1);
  logic [CW-1:0] cnt;
  logic wrap;

  assign wrap    = (cnt == CW'(HALF - 1));
  assign rise_tk = wrap && !sd_clk;
  assign fall_tk = wrap && sd_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sd_clk <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      sd_clk <= !sd_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdce_cmd_fsm.sv
module sdce_cmd_fsm
  import sdce_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_tk,
  input  logic             fall_tk,
  input  logic             start,
  input  logic [5:0]       idx,
  input  logic [31:0]      arg,
  input  logic             no_rsp,
  input  logic             long_rsp,
  input  logic             busy_wt,
  input  logic [TMO_W-1:0] tmo_start,
  input  logic             cmd_in,
  input  logic             dat0_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             done,
  output logic             err_to,
  output logic             err_crc,
  output logic             busy_irq,
  output logic [127:0]     rsp
);
  localparam int RX_W = LONG_BITS - 1;

  sdce_state_e      st;
  logic [TX_BITS-1:0] tx_sh;
  logic [RX_W-1:0]  rx_sh;
  logic [7:0]       cnt;
  logic [TMO_W-1:0] tmo;
  logic             m_norsp, m_long, m_busy;
  logic [6:0]       tx_crc, rx_crc;
  logic [7:0]       rx_last;

  sdce_crc7 #(.N(40)) u_tx_crc (.data({2'b01, idx, arg}), .crc(tx_crc));
  sdce_crc7 #(.N(40)) u_rx_crc (.data({1'b0, rx_sh[46:8]}), .crc(rx_crc));

  assign rx_last = m_long ? 8'(LONG_BITS - 1) : 8'(SHORT_BITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; tx_sh <= '0; rx_sh <= '0; cnt <= '0; tmo <= '0;
      m_norsp <= 1'b0; m_long <= 1'b0; m_busy <= 1'b0;
      cmd_out <= 1'b1; cmd_oe <= 1'b0;
      done <= 1'b0; err_to <= 1'b0; err_crc <= 1'b0; busy_irq <= 1'b0;
      rsp <= '0;
    end else begin
      done <= 1'b0; err_to <= 1'b0; err_crc <= 1'b0; busy_irq <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tx_sh   <= {2'b01, idx, arg, tx_crc, 1'b1};
          m_norsp <= no_rsp;
          m_long  <= long_rsp;
          m_busy  <= busy_wt;
          cnt     <= '0;
          st      <= S_SEND;
        end
        S_SEND: if (fall_tk) begin
          if (cnt == 8'(TX_BITS)) begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            if (m_norsp) begin
              if (m_busy) st <= S_BUSY;
              else begin st <= S_IDLE; done <= 1'b1; end
            end else begin
              st  <= S_WAIT;
              tmo <= tmo_start;
            end
          end else begin
            cmd_oe  <= 1'b1;
            cmd_out <= tx_sh[TX_BITS-1];
            tx_sh   <= {tx_sh[TX_BITS-2:0], 1'b0};
            cnt     <= cnt + 8'd1;
          end
        end
        S_WAIT: if (rise_tk) begin
          if (!cmd_in) begin
            st  <= S_RECV;
            cnt <= 8'd1;
          end else if (tmo == '0) begin
            st <= S_IDLE; done <= 1'b1; err_to <= 1'b1;
          end else begin
            tmo <= tmo - 1'b1;
          end
        end
        S_RECV: if (rise_tk) begin
          rx_sh <= {rx_sh[RX_W-2:0], cmd_in};
          cnt   <= cnt + 8'd1;
          if (cnt == rx_last) st <= S_CHECK;
        end
        S_CHECK: begin
          if (m_long) rsp <= rx_sh[127:0];
          else        rsp <= {96'b0, rx_sh[39:8]};
          if (!m_long && (rx_crc != rx_sh[7:1])) begin
            st <= S_IDLE; done <= 1'b1; err_crc <= 1'b1;
          end else if (m_busy) begin
            st <= S_BUSY;
          end else begin
            st <= S_IDLE; done <= 1'b1;
          end
        end
        S_BUSY: if (rise_tk && dat0_in) begin
          st <= S_IDLE; done <= 1'b1; busy_irq <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_oe) |-> $past(fall_tk));

  // R6
  tmo_from_wait_chk: assert property (@(posedge clk) disable iff (rst)
    err_to |-> $past(st == S_WAIT));

  // R11
  no_long_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !(long_rsp && busy_wt));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdce_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sd_clk,
  output logic              sd_cmd_out,
  output logic              sd_cmd_oe,
  input  logic              sd_cmd_in,
  input  logic              sd_dat0_in
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_RSP0 = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_RSP1 = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_RSP2 = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_RSP3 = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h20);

  logic [15:0]  cmd_q;
  logic [31:0]  arg_q, tmo_q, st_q;
  logic         rise_tk, fall_tk;
  logic         start, done, err_to, err_crc, busy_irq;
  logic [127:0] rsp;
  logic         cmd_wr, stat_wr, reject;
  logic [31:0]  clr_mask, set_mask;

  assign cmd_wr   = reg_we && (reg_addr == A_CMD) && !cmd_q[CW_GO];
  assign stat_wr  = reg_we && (reg_addr == A_STAT);
  assign reject   = reg_wdata[CW_LONG] && reg_wdata[CW_BUSY];
  assign start    = cmd_wr && reg_wdata[CW_GO] && !reject;
  assign clr_mask = stat_wr ? (reg_wdata & ST_MASK) : 32'd0;
  assign set_mask = (32'(err_crc) << ST_CRC7) | (32'(err_to) << ST_CMDTO) |
                    (32'(busy_irq) << ST_BUSY);

  sdce_clkgen #(.HALF(CLK_HALF)) u_clk (
    .clk(clk), .rst(rst), .sd_clk(sd_clk), .rise_tk(rise_tk), .fall_tk(fall_tk));

  sdce_cmd_fsm #(.TMO_W(32)) u_fsm (
    .clk(clk), .rst(rst), .rise_tk(rise_tk), .fall_tk(fall_tk),
    .start(start), .idx(reg_wdata[5:0]), .arg(arg_q),
    .no_rsp(reg_wdata[CW_NORSP]), .long_rsp(reg_wdata[CW_LONG]),
    .busy_wt(reg_wdata[CW_BUSY]), .tmo_start(tmo_q),
    .cmd_in(sd_cmd_in), .dat0_in(sd_dat0_in),
    .cmd_out(sd_cmd_out), .cmd_oe(sd_cmd_oe), .done(done),
    .err_to(err_to), .err_crc(err_crc), .busy_irq(busy_irq), .rsp(rsp));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; arg_q <= '0; tmo_q <= TMO_RESET; st_q <= '0;
    end else begin
      if (cmd_wr) begin
        cmd_q          <= reg_wdata[15:0] & CW_MASK;
        cmd_q[CW_FAIL] <= reg_wdata[CW_GO] && reject;
        cmd_q[CW_GO]   <= reg_wdata[CW_GO] && !reject;
      end else if (done) begin
        cmd_q[CW_GO]   <= 1'b0;
        cmd_q[CW_FAIL] <= err_to || err_crc;
      end
      if (reg_we && reg_addr == A_ARG) arg_q <= reg_wdata;
      if (reg_we && reg_addr == A_TMO) tmo_q <= reg_wdata;
      st_q <= (st_q & ~clr_mask) | set_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_CMD:   reg_rdata <= {16'b0, cmd_q};
        A_ARG:   reg_rdata <= arg_q;
        A_TMO:   reg_rdata <= tmo_q;
        A_RSP0:  reg_rdata <= rsp[31:0];
        A_RSP1:  reg_rdata <= rsp[63:32];
        A_RSP2:  reg_rdata <= rsp[95:64];
        A_RSP3:  reg_rdata <= rsp[127:96];
        A_STAT:  reg_rdata <= st_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R3
  go_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_q[CW_GO]) |-> $past(done));

  // R10
  busy_word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_q[CW_GO] && !done |=> $stable(cmd_q[13:0]));

  // R7
  w1c_only_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(st_q) & ~st_q) & ~$past(clr_mask)) == 32'd0);
endmodule

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sd_clk, sd_cmd_out, sd_cmd_oe;
  logic sd_cmd_in = 1'b1;
  logic sd_dat0_in = 1'b1;

  int checks = 0, errors = 0;
  logic [47:0] exp_q[$];
  logic [47:0] last_frame;
  int frames_seen = 0;
  int rsp_done_cnt = 0;
  int rsp_len = 0;
  logic [135:0] rsp_bits;
  int busy_len = 0;

  always #2 clk = !clk;

  sd_cmd_engine u_sd_cmd_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_clk(sd_clk),
    .sd_cmd_out(sd_cmd_out), .sd_cmd_oe(sd_cmd_oe),
    .sd_cmd_in(sd_cmd_in), .sd_dat0_in(sd_dat0_in));

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb;
      fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_frame(input logic tbit, input logic [5:0] idx,
                                           input logic [31:0] arg);
    return {1'b0, tbit, idx, arg, ref_crc({1'b0, tbit, idx, arg}), 1'b1};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      reg_rd(8'h00, v);
      if (!v[15]) return;
    end
    checks++; errors++;
    $display("FAIL R3 go never cleared actual=1 expected=0");
  endtask

  // driver: push expected frame, then start command
  task automatic issue(input logic [15:0] w, input logic [31:0] a, input bit expect_frame);
    if (expect_frame) exp_q.push_back(mk_frame(1'b1, w[5:0], a));
    reg_wr(8'h04, a);
    reg_wr(8'h00, {16'b0, w});
  endtask

  // monitor + card model
  initial begin
    forever begin
      @(posedge sd_clk);
      if (sd_cmd_oe) begin
        logic [47:0] f;
        f[47] = sd_cmd_out;
        for (int i = 46; i >= 0; i--) begin
          @(posedge sd_clk);
          f[i] = sd_cmd_out;
        end
        last_frame = f;
        frames_seen++;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected frame actual=%h expected=none", f);
        end else begin
          check("R2 frame", 32'(f[47:16] != exp_q[0][47:16] || f[15:0] != exp_q[0][15:0]), 32'd0);
          void'(exp_q.pop_front());
        end
        if (rsp_len > 0) begin
          repeat (2) @(negedge sd_clk);
          if (busy_len > 0) sd_dat0_in = 1'b0;
          sd_cmd_in = rsp_bits[rsp_len-1];
          for (int i = rsp_len - 2; i >= 0; i--) begin
            @(negedge sd_clk);
            sd_cmd_in = rsp_bits[i];
          end
          @(negedge sd_clk);
          sd_cmd_in = 1'b1;
          rsp_done_cnt++;
          if (busy_len > 0) begin
            repeat (busy_len) @(negedge sd_clk);
            sd_dat0_in = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [127:0] pay;
    int fs;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    reg_rd(8'h00, v); check("R1 cmd", v, 32'h0);
    reg_rd(8'h20, v); check("R1 status", v, 32'h0);
    reg_rd(8'h08, v); check("R1 timeout", v, 32'h00F0_0000);
    check("R1 oe", 32'(sd_cmd_oe), 32'd0);
    reg_wr(8'h08, 32'd50);

    // R2 / R12: no-response index 0, argument 0
    rsp_len = 0;
    issue(16'h8400, 32'h0, 1'b1);
    wait_idle();
    check("R2 crc byte cmd0", 32'(last_frame[7:0]), 32'h95);
    reg_rd(8'h00, v); check("R12 cmd after no-rsp", v, 32'h0000_0400);
    reg_rd(8'h20, v); check("R12 status", v, 32'h0);

    // R2: index 8 argument 0x1AA
    issue(16'h8408, 32'h1AA, 1'b1);
    wait_idle();
    check("R2 crc byte cmd8", 32'(last_frame[7:0]), 32'h87);

    // R4: short response
    rsp_bits = '0;
    rsp_bits[47:0] = mk_frame(1'b0, 6'd17, 32'hCAFE_1234);
    rsp_len = 48;
    issue(16'h8011, 32'h0000_0200, 1'b1);
    wait_idle();
    reg_rd(8'h10, v); check("R4 resp0", v, 32'hCAFE_1234);
    reg_rd(8'h00, v); check("R3 go cleared", v, 32'h0000_0011);
    reg_rd(8'h20, v); check("R4 status clean", v, 32'h0);

    // R5: bad CRC
    rsp_bits[47:0] = mk_frame(1'b0, 6'd13, 32'h0000_0900) ^ 48'h4;
    issue(16'h800D, 32'h0, 1'b1);
    wait_idle();
    reg_rd(8'h20, v); check("R5 crc status", v, 32'h10);
    reg_rd(8'h00, v); check("R5 fail flag", v, 32'h0000_400D);

    // R6: timeout
    rsp_len = 0;
    reg_wr(8'h08, 32'd20);
    issue(16'h8002, 32'h0, 1'b1);
    wait_idle();
    reg_rd(8'h20, v); check("R6 timeout status", v, 32'h50);
    reg_rd(8'h00, v); check("R6 fail flag", v, 32'h0000_4002);
    reg_wr(8'h08, 32'd50);

    // R7: write-one-to-clear
    reg_wr(8'h20, 32'h40);
    reg_rd(8'h20, v); check("R7 clear one bit", v, 32'h10);
    reg_wr(8'h20, 32'h0);
    reg_rd(8'h20, v); check("R7 zero write keeps", v, 32'h10);
    reg_wr(8'h20, 32'h10);
    reg_rd(8'h20, v); check("R7 cleared", v, 32'h0);

    // R8: long response
    pay = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
    rsp_bits = {8'h3F, pay};
    rsp_len = 136;
    issue(16'h8202, 32'h0, 1'b1);
    wait_idle();
    reg_rd(8'h10, v); check("R8 rsp0", v, pay[31:0]);
    reg_rd(8'h14, v); check("R8 rsp1", v, pay[63:32]);
    reg_rd(8'h18, v); check("R8 rsp2", v, pay[95:64]);
    reg_rd(8'h1C, v); check("R8 rsp3", v, pay[127:96]);
    reg_rd(8'h20, v); check("R8 no crc error", v, 32'h0);

    // R9: busy wait
    rsp_bits = '0;
    rsp_bits[47:0] = mk_frame(1'b0, 6'd7, 32'h0000_0700);
    rsp_len = 48;
    busy_len = 30;
    fs = rsp_done_cnt;
    issue(16'h8807, 32'h0, 1'b1);
    wait (rsp_done_cnt == fs + 1);
    repeat (20) @(posedge clk);
    reg_rd(8'h00, v); check("R9 go held in busy", 32'(v[15]), 32'd1);
    reg_rd(8'h20, v); check("R9 no busy bit yet", v, 32'h0);
    wait_idle();
    reg_rd(8'h20, v); check("R9 busy bit", v, 32'h400);
    reg_wr(8'h20, 32'h400);
    busy_len = 0;

    // R10: write while active ignored
    rsp_len = 0;
    fs = frames_seen;
    issue(16'h8405, 32'h1234_5678, 1'b1);
    reg_rd(8'h00, v); check("R10 active word", v, 32'h0000_8405);
    reg_wr(8'h00, 32'h0000_8409);
    reg_rd(8'h00, v); check("R10 word kept", v, 32'h0000_8405);
    wait_idle();
    repeat (600) @(posedge clk);
    check("R10 single frame", 32'(frames_seen - fs), 32'd1);

    // R11: long + busy rejected
    fs = frames_seen;
    issue(16'h8A02, 32'h0, 1'b0);
    reg_rd(8'h00, v); check("R11 rejected word", v, 32'h0000_4A02);
    repeat (600) @(posedge clk);
    check("R11 no frame", 32'(frames_seen - fs), 32'd0);
    check("R11 queue empty", 32'(exp_q.size()), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule